// File: doc/BRIEF.md
# Descriptor Flag Test-and-Set Sequencer

This block sets one flag bit in a 32-bit segment descriptor word while a segment is being loaded. For a code or data descriptor the flag is the accessed bit. For a task-state descriptor it is the busy bit. The caller gives a word address and a one-bit flag selector, then pulses `start`. The block drives a simple single-outstanding memory master port to carry out the update. When the update is finished it pulses `done` and presents the final descriptor word.

The sequence is always tried cheaply first. The block issues a plain, unlocked read of the word. If the chosen flag is already 1, the job finishes with no further bus traffic. If the flag is 0, the block opens one lock request that covers two accesses: a full-word read, then a write of that same word with the flag forced to 1. The lock is not released between the read and the write, so no other master can get in between them.

The data written comes from the locked read, not from the probe. Another master may set the flag after the probe. The write is still issued in that case, and it carries the flag set, so the number and kind of accesses never depend on such a race.

Top module: `desc_flag_setter`

## Requirements
- R1: After reset, `bus_req`, `bus_lock`, `bus_we`, `done` and `busy` are all 0.
- R2: A `start` pulse while idle makes the first bus access an unlocked read (`bus_we`=0, `bus_lock`=0) at `desc_addr`. `busy` is 1 from the cycle after `start` until the cycle `done` is high.
- R3: `flag_sel`=0 selects bit 8 of the word (accessed bit). `flag_sel`=1 selects bit 9 (busy bit). No other bit of the word is altered.
- R4: If the probe read returns the selected flag as 1, no further access is issued. `done` follows with `result` equal to the probe word.
- R5: If the probe read returns the selected flag as 0, exactly two more accesses follow at the same address: a locked full-word read, then a locked write. The write data equals the locked-read word with the selected flag set to 1.
- R6: `bus_lock` rises together with the request of the locked read. It stays 1 through every cycle up to and including the acknowledge of the locked write, and it is 0 in the cycle after that.
- R7: A raised request holds `bus_req`, `bus_addr`, `bus_we`, `bus_lock` and `bus_wdata` unchanged until `bus_ack` is seen. Each access completes in the cycle `bus_ack` is 1, and read data is taken from `bus_rdata` in that cycle.
- R8: `done` is high for exactly one cycle, in the cycle after the last acknowledge. In that cycle `result` holds the final descriptor word: the probe word in the R4 case, or the written word in the R5 case.
- R9: A `start` pulse while `busy` is 1 is ignored: it causes no extra access and does not change the address or flag of the update in progress.
- R10: If the probe found the flag clear but the locked read returns it set, the locked write is still issued. It carries the locked-read word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an update (accepted only when idle) |
| desc_addr | input | AW | Address of the descriptor word |
| flag_sel | input | 1 | 0 selects the accessed bit (bit 8), 1 selects the busy bit (bit 9) |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DW | Final descriptor word, valid while `done` is high |
| bus_req | output | 1 | Access request to the memory bus |
| bus_addr | output | AW | Access address |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_lock | output | 1 | Lock request spanning the read-modify-write |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Access completes in this cycle |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |

## Verification
The properties assume a well-behaved memory slave. It raises `bus_ack` only while `bus_req` is high, for one cycle per access, and it never acknowledges twice in a row. The bench's slave model keeps to this by dropping the acknowledge in the cycle after every completion and counting its latency afresh for each new request. Vectors vary that latency from zero to three cycles, use both flag selections and both initial flag values, and include a case where a second master sets the flag between the probe and the locked read. A `start` pulse is also injected in the middle of an update to confirm that it is ignored.

// File: rtl/desc_flag_setter.sv
module desc_flag_setter #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int ACC_BIT  = 8,
  parameter int BUSY_BIT = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] desc_addr,
  input  logic          flag_sel,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output logic          bus_lock,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_PROBE, S_LRD, S_LWR} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic          sel_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] result_q;
  logic          done_q;
  logic [DW-1:0] mask;

  assign mask = sel_q ? (DW'(1) << BUSY_BIT) : (DW'(1) << ACC_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      sel_q    <= 1'b0;
      wdata_q  <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            addr_q <= desc_addr;
            sel_q  <= flag_sel;
            st     <= S_PROBE;
          end
        S_PROBE:
          if (bus_ack) begin
            if ((bus_rdata & mask) != '0) begin
              result_q <= bus_rdata;
              done_q   <= 1'b1;
              st       <= S_IDLE;
            end else begin
              st <= S_LRD;
            end
          end
        S_LRD:
          if (bus_ack) begin
            wdata_q <= bus_rdata | mask;
            st      <= S_LWR;
          end
        S_LWR:
          if (bus_ack) begin
            result_q <= wdata_q;
            done_q   <= 1'b1;
            st       <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign result    = result_q;
  assign bus_req   = (st != S_IDLE);
  assign bus_addr  = addr_q;
  assign bus_we    = (st == S_LWR);
  assign bus_lock  = (st == S_LRD) || (st == S_LWR);
  assign bus_wdata = wdata_q;

endmodule

// File: rtl/desc_flag_setter_chk.sv
module desc_flag_setter_chk #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int ACC_BIT  = 8,
  parameter int BUSY_BIT = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          bus_req,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic          bus_lock,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ack
);

  p_lock_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock |-> bus_req);

  p_lock_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && !(bus_ack && bus_we)) |=> bus_lock);

  p_lock_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && bus_ack && bus_we) |=> !bus_lock);

  p_write_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> bus_lock);

  p_write_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (bus_wdata[ACC_BIT] || bus_wdata[BUSY_BIT]));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_lock) && $stable(bus_wdata)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  p_busy_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy == bus_req);

endmodule

bind desc_flag_setter desc_flag_setter_chk #(
  .AW(AW), .DW(DW), .ACC_BIT(ACC_BIT), .BUSY_BIT(BUSY_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .bus_req(bus_req), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_lock(bus_lock), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/desc_flag_setter_tb_top.sv
`timescale 1ns/1ps
module desc_flag_setter_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] desc_addr = '0;
  logic          flag_sel = 1'b0;
  logic          busy, done;
  logic [DW-1:0] result;
  logic          bus_req, bus_we, bus_lock;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  always #2.5 clk = ~clk;

  desc_flag_setter #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_addr(desc_addr),
    .flag_sel(flag_sel), .busy(busy), .done(done), .result(result),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_lock(bus_lock), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory slave model
  logic [31:0] mem [16];
  int          lat = 0;
  int          cnt = 0;
  bit          intf = 1'b0;
  logic [31:0] intf_mask = '0;
  int          ntr = 0;
  bit          tr_we [8];
  bit          tr_lock [8];
  logic [31:0] tr_addr [8];
  bit          prev_lock = 1'b0;
  bit          last_was_lwr = 1'b0;
  int          lock_gaps = 0;

  always @(negedge clk) begin
    if (prev_lock && !bus_lock && !last_was_lwr) lock_gaps++;
    prev_lock = bus_lock;
    if (bus_ack) begin
      bus_ack = 1'b0;
      cnt = 0;
    end else if (bus_req) begin
      if (cnt >= lat) begin
        bus_ack = 1'b1;
        if (ntr < 8) begin
          tr_we[ntr] = bus_we; tr_lock[ntr] = bus_lock; tr_addr[ntr] = bus_addr;
        end
        last_was_lwr = bus_we && bus_lock;
        if (bus_we) mem[bus_addr[5:2]] = bus_wdata;
        else begin
          bus_rdata = mem[bus_addr[5:2]];
          if (intf && ntr == 0) mem[bus_addr[5:2]] = mem[bus_addr[5:2]] | intf_mask;
        end
        ntr++;
      end else cnt++;
    end
  end

  // init, flag_sel, interfere, latency, expected result, expected access count
  typedef struct packed {
    logic [31:0] init;
    logic        sel;
    logic        intf;
    logic [3:0]  lat;
    logic [31:0] exp_res;
    logic [3:0]  exp_n;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 1'b0, 1'b0, 4'd0, 32'h0000_0100, 4'd3},
    '{32'h0000_0100, 1'b0, 1'b0, 4'd1, 32'h0000_0100, 4'd1},
    '{32'h0000_0200, 1'b0, 1'b0, 4'd2, 32'h0000_0300, 4'd3},
    '{32'h0000_0200, 1'b1, 1'b0, 4'd0, 32'h0000_0200, 4'd1},
    '{32'hFFFF_FCFF, 1'b1, 1'b0, 4'd3, 32'hFFFF_FEFF, 4'd3},
    '{32'hFFFF_FFFF, 1'b0, 1'b0, 4'd1, 32'hFFFF_FFFF, 4'd1},
    '{32'h1234_5000, 1'b0, 1'b1, 4'd1, 32'h1234_5100, 4'd3},
    '{32'hA5A5_A4A5, 1'b1, 1'b0, 4'd2, 32'hA5A5_A6A5, 4'd3}
  };

  task automatic kick(input logic [31:0] a, input logic s);
    @(negedge clk);
    desc_addr = a; flag_sel = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen, output logic [31:0] res);
    seen = 1'b0; res = '0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin seen = 1'b1; res = result; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    logic [31:0] res;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({bus_req, bus_lock, bus_we, done, busy} == 5'b0, "R1 reset outputs",
        {27'd0, bus_req, bus_lock, bus_we, done, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      mem[v] = VECS[v].init;
      lat = int'(VECS[v].lat);
      intf = VECS[v].intf;
      intf_mask = VECS[v].sel ? 32'h200 : 32'h100;
      ntr = 0; lock_gaps = 0;
      kick(32'(v * 4), VECS[v].sel);
      chk(busy == 1'b1, "R2 busy after start", {31'd0, busy}, 32'd1);
      wait_done(seen, res);
      chk(seen, "R8 done seen", {31'd0, seen}, 32'd1);
      chk(res == VECS[v].exp_res, "R8 R3 result word", res, VECS[v].exp_res);
      chk(ntr == int'(VECS[v].exp_n), (VECS[v].exp_n == 1) ? "R4 access count" : "R5 access count",
          32'(ntr), 32'(VECS[v].exp_n));
      chk(tr_we[0] == 1'b0 && tr_lock[0] == 1'b0 && tr_addr[0] == 32'(v * 4),
          "R2 first access unlocked read", tr_addr[0], 32'(v * 4));
      if (VECS[v].exp_n == 3) begin
        chk(!tr_we[1] && tr_lock[1] && tr_addr[1] == 32'(v * 4), "R5 locked read",
            {30'd0, tr_we[1], tr_lock[1]}, 32'd1);
        chk(tr_we[2] && tr_lock[2] && tr_addr[2] == 32'(v * 4), "R5 locked write",
            {30'd0, tr_we[2], tr_lock[2]}, 32'd3);
        chk(mem[v] == VECS[v].exp_res, VECS[v].intf ? "R10 written word" : "R5 R3 written word",
            mem[v], VECS[v].exp_res);
        chk(lock_gaps == 0, "R6 lock continuous", 32'(lock_gaps), 32'd0);
      end else begin
        chk(mem[v] == VECS[v].init, "R4 word untouched", mem[v], VECS[v].init);
      end
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", {31'd0, done}, 32'd0);
      chk(bus_lock == 1'b0 && busy == 1'b0, "R6 lock released", {30'd0, bus_lock, busy}, 32'd0);
    end

    // R9 start while busy is ignored
    mem[10] = 32'h0; mem[11] = 32'h0;
    lat = 3; intf = 1'b0; ntr = 0;
    kick(32'd40, 1'b1);
    @(negedge clk);
    desc_addr = 32'd44; flag_sel = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen, res);
    chk(seen && res == 32'h200, "R9 original job result", res, 32'h200);
    repeat (12) @(negedge clk);
    chk(ntr == 3, "R9 no extra access", 32'(ntr), 32'd3);
    chk(mem[11] == 32'h0, "R9 other word untouched", mem[11], 32'h0);
    chk(mem[10] == 32'h200, "R9 R3 busy bit set", mem[10], 32'h200);
    chk(busy == 1'b0 && bus_req == 1'b0, "R9 idle afterwards", {30'd0, busy, bus_req}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule